// File: doc/BRIEF.md
# Serial Loopback Enable Sequencer

This block drives a multi-lane serial link controller into or out of its internal transmit-to-receive loopback path. The controller is managed through a register port. A single start request, together with a mode input (1 = enter loopback, 0 = leave loopback), runs the whole procedure without further help.

The procedure has four steps. The sequencer pulses the controller's active-low reset. It then waits a programmable settle time before it makes any register access. When loopback is being entered, it writes the per-lane loopback mask. When loopback is being left, it relies on the reset having already cleared that mask. Last, it polls the lane-alignment status until the lanes report aligned or a poll budget runs out.

The outcome is reported on four outputs: done, busy, error and the mode currently in effect. Only one management transaction is ever outstanding.

Top module: `lpbk_seq`

## Requirements
- R1: After reset, busy, done, error and the mode flag are all 0, the controller reset output is high, and neither management write nor read is asserted.
- R2: A start accepted while idle drives the controller reset low for exactly RST_CYCLES consecutive cycles (RST_CYCLES >= 4). Busy is high from the cycle after the start until the outcome is reported, and management requests occur only while busy.
- R3: No management access is made during the controller reset or during the SETTLE_CYCLES cycles that follow its release. The first access is issued exactly SETTLE_CYCLES cycles after release.
- R4: When entering loopback, exactly one write is made before polling. It goes to address 0x12, with data bits [NUM_LANES-1:0] set to one and all higher bits of the 32-bit word zero.
- R5: When leaving loopback, no write is made; the sequence goes directly from the settle wait to polling.
- R6: Each poll is a read of address 0x20. Alignment is seen when bit ALIGN_BIT of the returned word is 1, or when the aligned_i input is high, in the cycle the read completes. All other read-data bits have no effect.
- R7: After a read that does not see alignment, the management port stays idle for exactly POLL_GAP cycles before the next read request.
- R8: When alignment is seen, busy falls, done rises, and the mode flag takes the requested mode. Done and error are never high together.
- R9: If POLL_LIMIT reads complete without alignment, error rises, done stays low, busy falls and the mode flag keeps its previous value.
- R10: A start request that arrives while busy is ignored: it does not produce a second controller reset and does not change the requested mode.
- R11: A management request holds its address, and for writes its data, steady while waitrequest is high. It ends on the first cycle with waitrequest low. Write and read are never asserted together.
- R12: Each accepted start clears done and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 1 | Requested mode: 1 enter loopback, 0 leave |
| aligned_i | input | 1 | Dedicated lanes-aligned indication from the controller |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence reached alignment |
| error_o | output | 1 | Last sequence ran out of polls |
| mode_o | output | 1 | Mode currently in effect (1 = loopback) |
| lnk_rst_n_o | output | 1 | Active-low reset to the link controller |
| mm_addr_o | output | ADDR_W | Management address |
| mm_wr_o | output | 1 | Management write request |
| mm_rd_o | output | 1 | Management read request |
| mm_wdata_o | output | 32 | Management write data |
| mm_rdata_i | input | 32 | Management read data, valid when a read completes |
| mm_wait_i | input | 1 | Management waitrequest |

## Verification
The bench builds the block with NUM_LANES=5, RST_CYCLES=6, SETTLE_CYCLES=10, POLL_GAP=3 and POLL_LIMIT=6. With these values the mask's upper-boundary bits, a measurable settle window and a poll budget short enough to exhaust are all within a brief run. The controller model answers polls with every bit except the alignment bit set until it decides the lanes are aligned. This shows that only the selected bit counts. The model also inserts random wait states, so that request holding is exercised. Random runs of both modes are mixed with directed cases: alignment on the first poll, alignment on the last poll, alignment arriving through the dedicated input, never-aligning controllers, and a start request made while busy.

// File: rtl/lpbk_seq_pkg.sv
package lpbk_seq_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_SETTLE,
    S_WRITE,
    S_READ,
    S_GAP
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Word with ones in the low n lane bits and zeros above.
  function automatic logic [DATA_W-1:0] lane_mask(input int unsigned n);
    logic [DATA_W-1:0] m;
    for (int unsigned i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // Alignment is reported by the chosen status bit or by the dedicated pin.
  function automatic logic align_hit(input logic [DATA_W-1:0] word,
                                     input int unsigned bitpos, input logic pin);
    return word[bitpos] | pin;
  endfunction

endpackage

// File: rtl/lpbk_timer.sv
module lpbk_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lpbk_mm_master.sv
module lpbk_mm_master #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_wr_i,
  input  logic          issue_rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [AW-1:0] mm_addr_o,
  output logic          mm_wr_o,
  output logic          mm_rd_o,
  output logic [DW-1:0] mm_wdata_o,
  input  logic          mm_wait_i
);
  logic          wr_q, rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign done_o = (wr_q | rd_q) & ~mm_wait_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue_wr_i || issue_rd_i) begin
      wr_q    <= issue_wr_i;
      rd_q    <= issue_rd_i & ~issue_wr_i;
      addr_q  <= addr_i;
      wdata_q <= issue_wr_i ? wdata_i : '0;
    end else if (done_o) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end
  end

  assign mm_addr_o  = addr_q;
  assign mm_wr_o    = wr_q;
  assign mm_rd_o    = rd_q;
  assign mm_wdata_o = wdata_q;
endmodule

// File: rtl/lpbk_seq.sv
module lpbk_seq
  import lpbk_seq_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 4,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned RST_CYCLES    = 8,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned POLL_GAP      = 4,
  parameter int unsigned POLL_LIMIT    = 8,
  parameter int unsigned ALIGN_BIT     = 1,
  parameter logic [ADDR_W-1:0] LOOP_ADDR  = 8'h12,
  parameter logic [ADDR_W-1:0] ALIGN_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              aligned_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              mode_o,
  output logic              lnk_rst_n_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic              mm_wr_o,
  output logic              mm_rd_o,
  output logic [31:0]       mm_wdata_o,
  input  logic [31:0]       mm_rdata_i,
  input  logic              mm_wait_i
);
  localparam int unsigned TMR_W = $clog2(max3(RST_CYCLES, SETTLE_CYCLES, POLL_GAP) + 1);
  localparam int unsigned PW    = $clog2(POLL_LIMIT + 1);
  localparam logic [DATA_W-1:0] MASK = lane_mask(NUM_LANES);

  generate
    if (RST_CYCLES < 4 || NUM_LANES < 1 || NUM_LANES > 24 || SETTLE_CYCLES < 1 ||
        POLL_GAP < 1 || POLL_LIMIT < 1 || ALIGN_BIT >= DATA_W) begin : g_bad_cfg
      $error("lpbk_seq: parameter out of range");
    end
  endgenerate

  seq_state_e        state_q;
  logic              req_mode_q;
  logic              busy_q, done_q, err_q, mode_q, lrst_n_q;
  logic [PW-1:0]     poll_q;

  // Named internal events.
  logic              start_take;
  logic              xfer_done;
  logic              rd_done;
  logic              aligned_seen;
  logic              polls_spent;
  logic              tmr_zero;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              issue_wr, issue_rd;
  logic [ADDR_W-1:0] issue_addr;
  logic              unused_rdata;

  assign unused_rdata = ^mm_rdata_i;
  assign start_take   = start_i && (state_q == S_IDLE);
  assign rd_done      = xfer_done && (state_q == S_READ);
  assign aligned_seen = align_hit(mm_rdata_i, ALIGN_BIT, aligned_i);
  assign polls_spent  = (poll_q == PW'(POLL_LIMIT - 1));

  lpbk_timer #(.W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  lpbk_mm_master #(.AW(ADDR_W), .DW(DATA_W)) u_mm (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_wr_i (issue_wr),
    .issue_rd_i (issue_rd),
    .addr_i     (issue_addr),
    .wdata_i    (MASK),
    .done_o     (xfer_done),
    .mm_addr_o  (mm_addr_o),
    .mm_wr_o    (mm_wr_o),
    .mm_rd_o    (mm_rd_o),
    .mm_wdata_o (mm_wdata_o),
    .mm_wait_i  (mm_wait_i)
  );

  always_comb begin
    tmr_load   = 1'b0;
    tmr_val    = '0;
    issue_wr   = 1'b0;
    issue_rd   = 1'b0;
    issue_addr = ALIGN_ADDR;
    unique case (state_q)
      S_IDLE: if (start_take) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RST_CYCLES - 1);
      end
      S_RST: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETTLE_CYCLES - 1);
      end
      S_SETTLE: if (tmr_zero) begin
        if (req_mode_q) begin
          issue_wr   = 1'b1;
          issue_addr = LOOP_ADDR;
        end else begin
          issue_rd   = 1'b1;
        end
      end
      S_WRITE: if (xfer_done) issue_rd = 1'b1;
      S_READ: if (rd_done && !aligned_seen && !polls_spent) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(POLL_GAP - 1);
      end
      S_GAP: if (tmr_zero) issue_rd = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      req_mode_q <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      mode_q     <= 1'b0;
      lrst_n_q   <= 1'b1;
      poll_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_take) begin
          state_q    <= S_RST;
          req_mode_q <= mode_i;
          busy_q     <= 1'b1;
          done_q     <= 1'b0;
          err_q      <= 1'b0;
          lrst_n_q   <= 1'b0;
          poll_q     <= '0;
        end
        S_RST: if (tmr_zero) begin
          lrst_n_q <= 1'b1;
          state_q  <= S_SETTLE;
        end
        S_SETTLE: if (tmr_zero) state_q <= req_mode_q ? S_WRITE : S_READ;
        S_WRITE:  if (xfer_done) state_q <= S_READ;
        S_READ: if (rd_done) begin
          if (aligned_seen) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            mode_q  <= req_mode_q;
          end else if (polls_spent) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
            err_q   <= 1'b1;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= S_GAP;
          end
        end
        S_GAP: if (tmr_zero) state_q <= S_READ;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign mode_o      = mode_q;
  assign lnk_rst_n_o = lrst_n_q;
endmodule

// File: rtl/lpbk_seq_chk.sv
module lpbk_seq_chk #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned RST_CYCLES    = 8,
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter logic [ADDR_W-1:0] LOOP_ADDR  = 8'h12,
  parameter logic [ADDR_W-1:0] ALIGN_ADDR = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              lnk_rst_n_o,
  input logic [ADDR_W-1:0] mm_addr_o,
  input logic              mm_wr_o,
  input logic              mm_rd_o,
  input logic [31:0]       mm_wdata_o,
  input logic              mm_wait_i
);
  localparam int unsigned LW = $clog2(RST_CYCLES + 2);
  localparam int unsigned HW = $clog2(SETTLE_CYCLES + 2);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (!lnk_rst_n_o) begin
      hi_cnt <= '0;
      if (lo_cnt != LW'(RST_CYCLES + 1)) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != HW'(SETTLE_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_rst_n_o) |-> lo_cnt == LW'(RST_CYCLES)); // R2
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr_o || mm_rd_o) |-> busy_o); // R2
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr_o || mm_rd_o) |-> (lnk_rst_n_o && hi_cnt == HW'(SETTLE_CYCLES))); // R3
  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mm_wr_o |-> mm_addr_o == LOOP_ADDR); // R4
  AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mm_rd_o |-> mm_addr_o == ALIGN_ADDR); // R6
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> !busy_o); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd_o && mm_wait_i) |=> (mm_rd_o && $stable(mm_addr_o))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr_o && mm_wait_i) |=> (mm_wr_o && $stable(mm_addr_o) && $stable(mm_wdata_o))); // R11
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_wr_o && mm_rd_o)); // R11
endmodule

bind lpbk_seq lpbk_seq_chk #(
  .ADDR_W        (ADDR_W),
  .RST_CYCLES    (RST_CYCLES),
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .LOOP_ADDR     (LOOP_ADDR),
  .ALIGN_ADDR    (ALIGN_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .lnk_rst_n_o (lnk_rst_n_o),
  .mm_addr_o   (mm_addr_o),
  .mm_wr_o     (mm_wr_o),
  .mm_rd_o     (mm_rd_o),
  .mm_wdata_o  (mm_wdata_o),
  .mm_wait_i   (mm_wait_i)
);

// File: tb/lpbk_seq_bench.sv
module lpbk_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 5;
  localparam int RSTC   = 6;
  localparam int SETTLE = 10;
  localparam int GAP    = 3;
  localparam int LIMIT  = 6;
  localparam int ABIT   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, pin = 1'b0;
  logic        busy, done, err, cur_mode, lrst_n;
  logic [7:0]  addr;
  logic        wr, rd, wait_w;
  logic [31:0] wdata, rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpbk_seq #(
    .NUM_LANES(LANES), .RST_CYCLES(RSTC), .SETTLE_CYCLES(SETTLE),
    .POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .ALIGN_BIT(ABIT)
  ) u_lpbk_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .aligned_i(pin),
    .busy_o(busy), .done_o(done), .error_o(err), .mode_o(cur_mode),
    .lnk_rst_n_o(lrst_n), .mm_addr_o(addr), .mm_wr_o(wr), .mm_rd_o(rd),
    .mm_wdata_o(wdata), .mm_rdata_i(rdata), .mm_wait_i(wait_w)
  );

  // Controller model and monitor.
  int          align_after = 0;  // 0 = never aligns
  logic        mon_clr = 1'b0;
  int          wcnt = 0;
  logic [31:0] loop_reg = '0;
  int          rd_seen = 0, rd_cnt = 0, wr_cnt = 0, bad_raddr = 0;
  logic [7:0]  last_waddr = '0;
  logic [31:0] last_wdata = '0;
  int          lo_len = 0, rst_falls = 0, since_rise = 0, settle_meas = -1;
  logic        first_req = 1'b0, prev_lrst = 1'b1, in_gap = 1'b0;
  int          gcnt = 0, gap_bad = 0, gap_seen = 0;
  logic        model_aligned;

  assign model_aligned = (align_after != 0) && (rd_seen + 1 >= align_after);
  assign wait_w = (wr || rd) && (wcnt != 0);
  assign rdata  = model_aligned ? (32'h1 << ABIT) : ~(32'h1 << ABIT);

  always @(posedge clk) begin
    if (mon_clr) begin
      rd_cnt <= 0; wr_cnt <= 0; bad_raddr <= 0; lo_len <= 0; rst_falls <= 0;
      settle_meas <= -1; first_req <= 1'b0; in_gap <= 1'b0; gcnt <= 0;
      gap_bad <= 0; gap_seen <= 0;
    end else begin
      prev_lrst <= lrst_n;
      if (prev_lrst && !lrst_n) rst_falls <= rst_falls + 1;
      if (!lrst_n) begin
        lo_len <= lo_len + 1; since_rise <= 0; first_req <= 1'b0;
        loop_reg <= '0; rd_seen <= 0;
      end else begin
        since_rise <= since_rise + 1;
        if ((wr || rd) && !first_req) begin
          settle_meas <= since_rise; first_req <= 1'b1;
        end
      end
      if (!(wr || rd) && in_gap) gcnt <= gcnt + 1;
      if ((wr || rd) && in_gap) begin
        if (gcnt != GAP) gap_bad <= gap_bad + 1;
        gap_seen <= gap_seen + 1;
        in_gap <= 1'b0;
      end
      if (wr || rd) begin
        if (wcnt != 0) wcnt <= wcnt - 1;
        else begin
          wcnt <= int'($urandom % 3);
          if (wr) begin
            wr_cnt <= wr_cnt + 1; last_waddr <= addr; last_wdata <= wdata;
            if (addr == 8'h12) loop_reg <= wdata;
          end else begin
            rd_cnt <= rd_cnt + 1; rd_seen <= rd_seen + 1;
            if (addr != 8'h20) bad_raddr <= bad_raddr + 1;
            if (!model_aligned && !pin) begin in_gap <= 1'b1; gcnt <= 0; end
          end
        end
      end
    end
  end

  int   n_chk = 0, n_err = 0;
  logic exp_mode = 1'b0;
  int   cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m = m | (32'h1 << i);
    return m;
  endfunction

  function automatic bit exp_ok(input int after, input bit p);
    return p || (after != 0 && after <= LIMIT);
  endfunction

  function automatic int exp_reads(input int after, input bit p);
    if (p) return 1;
    return (after != 0 && after <= LIMIT) ? after : LIMIT;
  endfunction

  task automatic run_seq(input bit m, input int after, input bit p, input bit poke);
    bit ok;
    int to;
    @(negedge clk);
    mon_clr = 1'b1; align_after = after; pin = p;
    @(negedge clk);
    mon_clr = 1'b0; start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done == 1'b0 && err == 1'b0, "R12 flags cleared", int'({done, err}), 0);
    if (poke) begin
      repeat (RSTC + 3) @(negedge clk);
      start = 1'b1; mode = ~m;
      @(negedge clk);
      start = 1'b0;
    end
    to = 0;
    while (busy && to < 2000) begin @(negedge clk); to++; end
    chk(to < 2000, "R8 sequence ends", to, 0);
    ok = exp_ok(after, p);
    if (ok) exp_mode = m;
    chk(rst_falls == 1, "R10 single reset", rst_falls, 1);
    chk(lo_len == RSTC, "R2 reset width", lo_len, RSTC);
    chk(settle_meas == SETTLE, "R3 settle wait", settle_meas, SETTLE);
    chk(wr_cnt == (m ? 1 : 0), m ? "R4 one write" : "R5 no write", wr_cnt, m ? 1 : 0);
    if (m) begin
      chk(last_waddr == 8'h12, "R4 write addr", int'(last_waddr), 'h12);
      chk(last_wdata == exp_mask(LANES), "R4 mask data", int'(last_wdata),
          int'(exp_mask(LANES)));
    end
    chk(loop_reg == (m ? exp_mask(LANES) : 32'h0), m ? "R4 mask held" : "R5 mask cleared",
        int'(loop_reg), m ? int'(exp_mask(LANES)) : 0);
    chk(rd_cnt == exp_reads(after, p), ok ? "R6 reads to align" : "R9 reads to timeout",
        rd_cnt, exp_reads(after, p));
    chk(bad_raddr == 0, "R6 read addr", bad_raddr, 0);
    chk(gap_bad == 0 && gap_seen == exp_reads(after, p) - 1, "R7 poll gap",
        gap_seen - gap_bad, exp_reads(after, p) - 1);
    chk(done == ok, "R8 done", int'(done), int'(ok));
    chk(err == !ok, "R9 error", int'(err), int'(!ok));
    chk(cur_mode == exp_mode, "R8 R9 mode flag", int'(cur_mode), int'(exp_mode));
    chk(!wr && !rd && lrst_n, "R2 quiet when idle", int'({wr, rd, lrst_n}), 1);
    pin = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !cur_mode, "R1 flags in reset", int'({busy, done, err, cur_mode}), 0);
    chk(lrst_n && !wr && !rd, "R1 port idle in reset", int'({lrst_n, wr, rd}), 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !cur_mode && lrst_n, "R1 after reset", int'({busy, done, err}), 0);
    // Directed corners.
    run_seq(1'b1, 1, 1'b0, 1'b0);      // align on first poll
    run_seq(1'b0, LIMIT, 1'b0, 1'b0);  // align on last poll
    run_seq(1'b1, 0, 1'b0, 1'b0);      // never aligns: timeout R9
    run_seq(1'b1, 0, 1'b1, 1'b0);      // aligned through pin R6
    run_seq(1'b1, 3, 1'b0, 1'b1);      // start while busy R10
    run_seq(1'b0, LIMIT + 1, 1'b0, 1'b0); // one too late: timeout
    // Random runs.
    for (int k = 0; k < 12; k++)
      run_seq(1'($urandom % 2), int'($urandom % (LIMIT + 2)), 1'b0, 1'($urandom % 2));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule